// File: doc/BRIEF.md
# Bit-Alias Bus Bridge

This bridge sits between a CPU-side request port and a byte-addressable SRAM port. A 32 MB alias window is decoded so that every 32-bit word address in it names one bit of a 1 MB target region. A read of such a word returns that single bit as the value 0 or 1. A write changes only that bit, through a locked read-modify-write on the SRAM.

The translation is applied only when the request is marked as coming from the CPU. Requests from any other master, and all addresses outside the window, are forwarded to the SRAM untouched, with their own byte strobes.

The CPU holds its request until `cpu_ready` pulses for one cycle. During an alias write the bridge keeps the CPU not-ready. It also keeps the SRAM bus quiet between the read phase and the write phase.

Top module: `bitband_bridge`

## Requirements
- R1: For a CPU request whose address A satisfies A[31:25] == 0x22 >> 1 (window 0x22000000 to 0x23FFFFFF), the target byte is 0x20000000 + A[24:5] and the target bit is A[4:2]. A[1:0] is ignored. Example: 0x22006008 selects bit 2 of byte 0x20000300. The SRAM word address is the target byte address with bits [1:0] cleared, and the byte lane is the target byte address bits [1:0].
- R2: An alias read returns 0x00000001 if the target bit is 1 and 0x00000000 if it is 0. `cpu_ready` rises after the third rising edge counted from the first edge that sees the request. The SRAM sees exactly one read of the target word.
- R3: An alias write sets the target bit to bit 0 of `cpu_wdata`. Write-data bits [31:1] and `cpu_be` are ignored. Every other bit of the target byte and of the other SRAM bytes keeps its value.
- R4: An alias write issues exactly two SRAM operations: first a read of the target word, then, two cycles later, a write of that word with only the target lane's strobe set. No SRAM request is made in the cycle between them. `cpu_ready` rises after the fourth rising edge.
- R5: A request outside the window is forwarded with unchanged address, data, write flag and strobes. Read data is returned unchanged, and `cpu_ready` rises after the third rising edge.
- R6: A request with `cpu_is_cpu` = 0 is forwarded untranslated even when its address lies in the alias window.
- R7: `cpu_ready` is high for exactly one cycle per request.
- R8: While and right after reset, `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, held until cpu_ready |
| cpu_is_cpu | input | 1 | 1 when the requester is the CPU master |
| cpu_we | input | 1 | 1 for write |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte strobes |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | SRAM operation this cycle |
| mem_we | output | 1 | SRAM write |
| mem_addr | output | 32 | SRAM byte address (word aligned for alias traffic) |
| mem_wdata | output | 32 | SRAM write data |
| mem_be | output | 4 | SRAM byte strobes |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read |

## Verification
An alias write has to read and later write one SRAM word, while the SRAM contents around that word must stay exactly as the CPU last left them. The bench therefore mixes alias writes with passthrough writes that fill the neighbouring bits of the same words with random patterns. After every alias write it compares all four bytes of the word against a behavioural byte model. It also logs every SRAM operation with its cycle number, so the read phase, the empty gap cycle and the single-lane write phase are each judged separately.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int unsigned DW  = 32;
    localparam int unsigned AW  = 32;
    localparam int unsigned BEW = DW / 8;
    localparam int unsigned LW  = $clog2(BEW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_RMW_RD,
        ST_RMW_MOD,
        ST_RMW_WR
    } bb_state_e;

    typedef struct packed {
        bb_state_e        state;
        logic             alias_hit;
        logic             write;
        logic [2:0]       bit_sel;
        logic [LW-1:0]    lane;
        logic             new_bit;
        logic             mem_req;
        logic             mem_we;
        logic [AW-1:0]    mem_addr;
        logic [DW-1:0]    mem_wdata;
        logic [BEW-1:0]   mem_be;
        logic             ready;
        logic [DW-1:0]    rdata;
    } bb_regs_t;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter logic [AW-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [AW-1:0] TARGET_BASE = 32'h2000_0000,
    parameter int unsigned   SPAN_LOG2   = 25
) (
    input  logic [AW-1:0] addr,
    input  logic          from_cpu,
    output logic          hit,
    output logic [AW-1:0] word_addr,
    output logic [LW-1:0] lane,
    output logic [2:0]    bit_sel
);
    localparam int unsigned OFF_LO = 5;
    localparam int unsigned OFF_W  = SPAN_LOG2 - OFF_LO;

    logic [OFF_W-1:0] byte_off;
    logic [AW-1:0]    byte_addr;

    always_comb begin
        hit       = from_cpu && (addr[AW-1:SPAN_LOG2] == ALIAS_BASE[AW-1:SPAN_LOG2]);
        byte_off  = addr[SPAN_LOG2-1:OFF_LO];
        byte_addr = TARGET_BASE + {{(AW-OFF_W){1'b0}}, byte_off};
        word_addr = {byte_addr[AW-1:LW], {LW{1'b0}}};
        lane      = byte_addr[LW-1:0];
        bit_sel   = addr[4:2];
    end
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
(
    input  logic [DW-1:0]  word_in,
    input  logic [LW-1:0]  lane,
    input  logic [2:0]     bit_sel,
    input  logic           new_bit,
    output logic           bit_val,
    output logic [DW-1:0]  merged,
    output logic [BEW-1:0] lane_be
);
    logic [BEW-1:0] bit_per_lane;

    for (genvar g = 0; g < BEW; g++) begin : g_lane
        logic [7:0] slice;
        logic [7:0] upd;
        always_comb begin
            slice           = word_in[g*8 +: 8];
            upd             = slice;
            upd[bit_sel]    = new_bit;
            bit_per_lane[g] = slice[bit_sel];
            merged[g*8 +: 8] = (lane == LW'(g)) ? upd : slice;
            lane_be[g]      = (lane == LW'(g));
        end
    end

    assign bit_val = bit_per_lane[lane];
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
    parameter int unsigned SPAN_LOG2   = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_is_cpu,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic [3:0]  cpu_be,
    output logic [31:0] cpu_rdata,
    output logic        cpu_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata
);
    bb_regs_t r_q, r_d;

    logic          dec_hit;
    logic [AW-1:0] dec_word;
    logic [LW-1:0] dec_lane;
    logic [2:0]    dec_bit;

    bb_alias_decode #(
        .ALIAS_BASE (ALIAS_BASE),
        .TARGET_BASE(TARGET_BASE),
        .SPAN_LOG2  (SPAN_LOG2)
    ) u_dec (
        .addr     (cpu_addr),
        .from_cpu (cpu_is_cpu),
        .hit      (dec_hit),
        .word_addr(dec_word),
        .lane     (dec_lane),
        .bit_sel  (dec_bit)
    );

    logic           sel_bit;
    logic [DW-1:0]  merged_word;
    logic [BEW-1:0] merged_be;

    bb_bit_lane u_lane (
        .word_in(mem_rdata),
        .lane   (r_q.lane),
        .bit_sel(r_q.bit_sel),
        .new_bit(r_q.new_bit),
        .bit_val(sel_bit),
        .merged (merged_word),
        .lane_be(merged_be)
    );

    always_comb begin
        r_d         = r_q;
        r_d.mem_req = 1'b0;
        r_d.ready   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req && !r_q.ready) begin
                    r_d.alias_hit = dec_hit;
                    r_d.write     = cpu_we;
                    r_d.bit_sel   = dec_bit;
                    r_d.lane      = dec_lane;
                    r_d.new_bit   = cpu_wdata[0];
                    r_d.mem_req   = 1'b1;
                    if (dec_hit) begin
                        r_d.mem_we    = 1'b0;
                        r_d.mem_addr  = dec_word;
                        r_d.mem_wdata = '0;
                        r_d.mem_be    = {BEW{1'b1}};
                        r_d.state     = cpu_we ? ST_RMW_RD : ST_ISSUE;
                    end else begin
                        r_d.mem_we    = cpu_we;
                        r_d.mem_addr  = cpu_addr;
                        r_d.mem_wdata = cpu_wdata;
                        r_d.mem_be    = cpu_be;
                        r_d.state     = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE:   r_d.state = ST_RESP;
            ST_RESP: begin
                r_d.ready = 1'b1;
                r_d.rdata = r_q.alias_hit ? {{(DW-1){1'b0}}, sel_bit} : mem_rdata;
                r_d.state = ST_IDLE;
            end
            ST_RMW_RD:  r_d.state = ST_RMW_MOD;
            ST_RMW_MOD: begin
                r_d.mem_req   = 1'b1;
                r_d.mem_we    = 1'b1;
                r_d.mem_wdata = merged_word;
                r_d.mem_be    = merged_be;
                r_d.state     = ST_RMW_WR;
            end
            ST_RMW_WR: begin
                r_d.ready = 1'b1;
                r_d.rdata = '0;
                r_d.state = ST_IDLE;
            end
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_rdata = r_q.rdata;
    assign cpu_ready = r_q.ready;
    assign mem_req   = r_q.mem_req;
    assign mem_we    = r_q.mem_we;
    assign mem_addr  = r_q.mem_addr;
    assign mem_wdata = r_q.mem_wdata;
    assign mem_be    = r_q.mem_be;
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
    parameter logic [31:0] TARGET_BASE = 32'h2000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ready,
    input logic [31:0] cpu_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        acc_alias,
    input logic        acc_write
);
    AST_ALIAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && acc_alias |-> (mem_addr[31:20] == TARGET_BASE[31:20]) && (mem_addr[1:0] == 2'b00)); // R1

    AST_ALIAS_RD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && acc_alias && !acc_write |-> (cpu_rdata[31:1] == 31'd0)); // R2

    AST_RMW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && acc_alias |-> ($countones(mem_be) == 1)); // R3

    AST_RMW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && acc_alias && acc_write |=> !mem_req); // R4

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R7

    AST_NO_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R4
endmodule

bind bitband_bridge bb_checker #(.TARGET_BASE(TARGET_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .acc_alias(r_q.alias_hit),
    .acc_write(r_q.write)
);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_is_cpu = 1'b1, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    bitband_bridge u_bitband_bridge (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_is_cpu(cpu_is_cpu), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;

    bit [7:0] sram [bit [31:0]];
    bit [7:0] refm [bit [31:0]];

    logic        op_we  [$];
    logic [31:0] op_adr [$];
    logic [3:0]  op_be  [$];
    int          op_cyc [$];

    function automatic bit [7:0] rd_b(input bit [31:0] a, input bit use_ref);
        if (use_ref) return refm.exists(a) ? refm[a] : 8'h00;
        return sram.exists(a) ? sram[a] : 8'h00;
    endfunction

    function automatic bit [31:0] rd_w(input bit [31:0] a, input bit use_ref);
        bit [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = rd_b({a[31:2], 2'b00} + i, use_ref);
        return w;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            op_we.push_back(mem_we);
            op_adr.push_back(mem_addr);
            op_be.push_back(mem_be);
            op_cyc.push_back(cyc);
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) sram[{mem_addr[31:2], 2'b00} + i] = mem_wdata[i*8 +: 8];
            end else begin
                mem_rdata <= rd_w(mem_addr, 1'b0);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit src, input bit we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int n);
        op_we.delete(); op_adr.delete(); op_be.delete(); op_cyc.delete();
        cpu_req = 1'b1; cpu_is_cpu = src; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!cpu_ready && n < 20);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b0, "R7 ready pulse", {31'd0, cpu_ready}, 32'd0);
    endtask

    task automatic ref_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        for (int i = 0; i < 4; i++) if (be[i]) refm[{a[31:2], 2'b00} + i] = d[i*8 +: 8];
    endtask

    task automatic alias_write(input logic [31:0] byte_a, input int b, input bit v, input logic [31:0] junk);
        logic [31:0] rd;
        int n;
        logic [31:0] aa;
        logic [31:0] wa;
        aa = 32'h2200_0000 + ((byte_a - 32'h2000_0000) << 5) + (b << 2) + {30'd0, junk[1:0]};
        wa = {byte_a[31:2], 2'b00};
        access(1'b1, 1'b1, aa, {junk[31:1], v}, junk[7:4], rd, n);
        check(n == 4, "R4 write latency", n, 4);
        check(op_we.size() == 2, "R4 op count", op_we.size(), 2);
        if (op_we.size() == 2) begin
            check(op_we[0] == 1'b0 && op_adr[0] == wa, "R1 read phase addr", op_adr[0], wa);
            check(op_we[1] == 1'b1 && op_adr[1] == wa, "R1 write phase addr", op_adr[1], wa);
            check(op_be[1] == (4'b1 << byte_a[1:0]), "R4 write lane", {28'd0, op_be[1]}, 32'(4'b1 << byte_a[1:0]));
            check(op_cyc[1] - op_cyc[0] == 2, "R4 gap cycle", op_cyc[1] - op_cyc[0], 2);
        end
        refm[byte_a] = rd_b(byte_a, 1'b1);
        refm[byte_a][b] = v;
        check(rd_w(wa, 1'b0) == rd_w(wa, 1'b1), "R3 word after alias write", rd_w(wa, 1'b0), rd_w(wa, 1'b1));
    endtask

    task automatic alias_read(input logic [31:0] byte_a, input int b);
        logic [31:0] rd;
        int n;
        logic [31:0] aa;
        logic [31:0] exp;
        aa = 32'h2200_0000 + ((byte_a - 32'h2000_0000) << 5) + (b << 2);
        exp = {31'd0, rd_b(byte_a, 1'b1)[b]};
        access(1'b1, 1'b0, aa, $urandom, 4'hF, rd, n);
        check(rd == exp, "R2 alias read value", rd, exp);
        check(n == 3, "R2 read latency", n, 3);
        check(op_we.size() == 1, "R2 single read", op_we.size(), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] rd, d;
        int n;
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R8 in reset", {30'd0, cpu_ready, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R8 after reset", {30'd0, cpu_ready, mem_req}, 0);

        // prefill through the passthrough path (R5)
        for (int k = 0; k < 4; k++) begin
            d = $urandom;
            access(1'b1, 1'b1, 32'h2000_0000 + k*4, d, 4'hF, rd, n);
            ref_write(32'h2000_0000 + k*4, d, 4'hF);
            d = $urandom;
            access(1'b1, 1'b1, 32'h2000_0300 + k*4, d, 4'hF, rd, n);
            ref_write(32'h2000_0300 + k*4, d, 4'hF);
        end

        // R5 partial strobes forwarded unchanged
        access(1'b1, 1'b1, 32'h2000_0306, 32'hDEAD_BEEF, 4'b0101, rd, n);
        ref_write(32'h2000_0306, 32'hDEAD_BEEF, 4'b0101);
        check(n == 3, "R5 passthrough write latency", n, 3);
        check(op_adr.size() == 1 && op_adr[0] == 32'h2000_0306 && op_be[0] == 4'b0101,
              "R5 forwarded addr/strobes", op_adr.size() ? op_adr[0] : 0, 32'h2000_0306);
        access(1'b1, 1'b0, 32'h2000_0304, 32'h0, 4'hF, rd, n);
        check(rd == rd_w(32'h2000_0304, 1'b1), "R5 passthrough read data", rd, rd_w(32'h2000_0304, 1'b1));
        check(n == 3, "R5 passthrough read latency", n, 3);

        // R1 example address: bit 2 of byte 0x20000300
        access(1'b1, 1'b1, 32'h2200_6008, 32'h1, 4'hF, rd, n);
        refm[32'h2000_0300][2] = 1'b1;
        check(op_adr.size() == 2 && op_adr[0] == 32'h2000_0300 && op_be[1] == 4'b0001,
              "R1 example decode", op_adr.size() ? op_adr[0] : 0, 32'h2000_0300);
        check(rd_b(32'h2000_0300, 1'b0) == rd_b(32'h2000_0300, 1'b1), "R1 example byte",
              rd_b(32'h2000_0300, 1'b0), rd_b(32'h2000_0300, 1'b1));
        alias_read(32'h2000_0300, 2);

        // R3 high write-data bits ignored: 0xFFFFFFFE clears the bit
        alias_write(32'h2000_0300, 2, 1'b0, 32'hFFFF_FFFE);
        alias_read(32'h2000_0300, 2);

        // random set/clear/readback, neighbours checked (R2 R3 R4)
        for (int it = 0; it < 48; it++) begin
            logic [31:0] ba;
            ba = ((it & 1) ? 32'h2000_0300 : 32'h2000_0000) + ($urandom % 16);
            alias_write(ba, $urandom % 8, $urandom % 2, $urandom);
            alias_read(ba, $urandom % 8);
        end

        // R6 non-CPU master is not translated
        access(1'b0, 1'b1, 32'h2200_6008, 32'hA5A5_5A5A, 4'hF, rd, n);
        ref_write(32'h2200_6008, 32'hA5A5_5A5A, 4'hF);
        check(op_adr.size() == 1 && op_adr[0] == 32'h2200_6008, "R6 raw address forwarded",
              op_adr.size() ? op_adr[0] : 0, 32'h2200_6008);
        check(rd_w(32'h2000_0300, 1'b0) == rd_w(32'h2000_0300, 1'b1), "R6 target untouched",
              rd_w(32'h2000_0300, 1'b0), rd_w(32'h2000_0300, 1'b1));
        access(1'b0, 1'b0, 32'h2200_6008, 32'h0, 4'hF, rd, n);
        check(rd == 32'hA5A5_5A5A, "R6 raw read data", rd, 32'hA5A5_5A5A);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule